// File: doc/BRIEF.md
# TLB Entry Access Register Bank

This block holds the entries of two translation lookaside buffer banks and the small set of support registers through which software reaches them. Each bank is organised as four ways of sixteen entries, and every entry is a pair of 32-bit words: a high word that carries the virtual page number and a low word that carries the physical side and a valid bit. Software never addresses an entry directly. It first writes a select register that names a way and an entry index, and then works through a high mirror, a low mirror and a cause register.

The bank that is addressed comes from a two-bit support-set selector. The codes 1 and 2 reach bank 0 and bank 1. The codes 0 and 3 reach neither: writes under them change nothing and reads under them return zero. A write to the low word commits a whole entry in one step. The low half comes from the written data and the high half comes from the cause register, which a write to the high word loads beforehand. Every commit also sends a one-cycle request to invalidate the page that the old entry mapped, so that any cached translation of it is dropped. Every read in an active set first reloads both mirrors from the selected entry, and then returns the requested register one cycle later.

Top module: `tlb_support_bank`

## Requirements
- R1: After a synchronous active-low reset every entry, both mirrors, the cause register and the select register read as zero, and `rd_valid` and `inv_valid` are low.
- R2: Only `bank_sel` values 1 and 2 are active, reaching bank 0 and bank 1. Under the values 0 and 3, writes change no register or entry and raise no invalidate. Reads under them return zero and leave the mirrors alone.
- R3: Register address 4 is the select register. It keeps `wr_data[5:0]`, with the way in bits [5:4] and the entry index in bits [3:0]. A read returns that value zero-extended.
- R4: A write to address 6 (entry high) loads the value into the high mirror and also into the cause register. The cause register reads back at address 7.
- R5: The cause register is read-only: a write to address 7 leaves it unchanged.
- R6: A write to address 5 (entry low) stores the written value as the low word and the cause register as the high word. Both go into the entry picked by the active bank and the select register.
- R7: The cycle after each commit, `inv_valid` is high for exactly one cycle. `inv_addr` then equals the replaced entry's old high word with bits [12:0] cleared. `inv_old_valid` equals bit 3 of the replaced entry's old low word. Commits on back-to-back cycles give back-to-back pulses.
- R8: A read with `wr_en` low raises `rd_valid` the next cycle with the requested register on `rd_data`. In an active set the read first reloads both mirrors from the selected entry. Reads of addresses 5 and 6 therefore return the stored entry words, even after a later write to address 6 that has not been committed.
- R9: When `wr_en` and `rd_en` are high in the same cycle, the write is performed and the read is dropped, so `rd_valid` stays low.
- R10: Entries are independent across banks and ways. A commit changes only the one entry that the active bank, way and index name.
- R11: In an active set, addresses other than 4 to 7 have no storage: writes to them are ignored and reads of them return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| bank_sel | input | 2 | Support-set selector; 1 and 2 reach bank 0 and bank 1 |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| reg_addr | input | 4 | Support register address |
| wr_data | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after the read |
| rd_data | output | 32 | Read data, zero when `rd_valid` is low |
| inv_valid | output | 1 | One-cycle page invalidate request |
| inv_addr | output | 32 | Page-aligned virtual address to invalidate |
| inv_old_valid | output | 1 | Valid bit of the entry that was replaced |

## Verification
The hardest case to reach from the ports is an invalidate whose address and valid bit are both non-zero. That needs an entry that already holds a page. Software must write the high word, commit, and then commit again to the same way and index, and the second invalidate must carry the first entry's page even though the cause register now holds something else. The stimulus sweeps all four ways of one index this way in both banks. It also makes a high-word write, leaves it uncommitted and then reads the entry. That read must return the stored high word, while the cause register still holds the uncommitted value.

// File: rtl/tlbsr_pkg.sv
// Shared definitions for the TLB support register bank.
// Assumes exactly two TLB banks, reached through selector codes 1 and 2.
package tlbsr_pkg;

    localparam int unsigned NUM_BANKS = 2;

    // One decoded register access, produced once per cycle by the decoder.
    typedef struct packed {
        logic active;   // selector names one of the TLB banks
        logic bank;     // which TLB bank (0 or 1)
        logic wr_sel;   // write to the select register
        logic wr_lo;    // write to entry low: commits an entry
        logic wr_hi;    // write to entry high: loads the mirror and the cause
        logic rd;       // read accepted (no write in the same cycle)
        logic reload;   // accepted read in an active set: reload the mirrors
    } tlbsr_dec_t;

endpackage

// File: rtl/tlbsr_decode.sv
// Access decoder. Turns the raw strobes, selector and address into
// one-hot actions. Assumes a write has priority over a read in the same cycle.
module tlbsr_decode
    import tlbsr_pkg::*;
#(
    parameter int unsigned       ADDR_W   = 4,
    parameter logic [ADDR_W-1:0] SEL_ADDR = 4,
    parameter logic [ADDR_W-1:0] LO_ADDR  = 5,
    parameter logic [ADDR_W-1:0] HI_ADDR  = 6
) (
    input  logic [1:0]        bank_sel,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] reg_addr,
    output tlbsr_dec_t        dec
);

    logic wr_act;

    // Decode the selector, then qualify each register action with it.
    always_comb begin
        dec        = '0;
        dec.active = (bank_sel == 2'd1) || (bank_sel == 2'd2);
        dec.bank   = (bank_sel == 2'd2);
        wr_act     = wr_en && dec.active;
        dec.wr_sel = wr_act && (reg_addr == SEL_ADDR);
        dec.wr_lo  = wr_act && (reg_addr == LO_ADDR);
        dec.wr_hi  = wr_act && (reg_addr == HI_ADDR);
        dec.rd     = rd_en && !wr_en;
        dec.reload = dec.rd && dec.active;
    end

endmodule

// File: rtl/tlbsr_store.sv
// Entry storage: NUM_BANKS banks of 2**SLOT_W entries, each a high and a
// low word held in flops. Assumes the slot index is the select register
// {way, index}. Gives a combinational read of the addressed entry, which
// is the old value during a commit.
module tlbsr_store
    import tlbsr_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned SLOT_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  logic              bank,
    input  logic [SLOT_W-1:0] slot,
    input  logic [DATA_W-1:0] new_lo,
    input  logic [DATA_W-1:0] new_hi,
    output logic [DATA_W-1:0] cur_lo,
    output logic [DATA_W-1:0] cur_hi
);

    localparam int unsigned SLOTS = 1 << SLOT_W;

    logic [DATA_W-1:0] bank_lo [NUM_BANKS];
    logic [DATA_W-1:0] bank_hi [NUM_BANKS];

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic [DATA_W-1:0] lo_mem [SLOTS];
        logic [DATA_W-1:0] hi_mem [SLOTS];

        // Clear on reset; on a commit to this bank, write the addressed entry.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int i = 0; i < SLOTS; i++) begin
                    lo_mem[i] <= '0;
                    hi_mem[i] <= '0;
                end
            end else if (commit && (bank == 1'(b))) begin
                lo_mem[slot] <= new_lo;
                hi_mem[slot] <= new_hi;
            end
        end

        assign bank_lo[b] = lo_mem[slot];
        assign bank_hi[b] = hi_mem[slot];
    end

    // Pick the addressed entry of the active bank.
    always_comb begin
        cur_lo = bank_lo[bank];
        cur_hi = bank_hi[bank];
    end

endmodule

// File: rtl/tlbsr_regs.sv
// Select, cause and mirror registers. Assumes the decoder has already
// qualified every action with an active bank. The mirrors take written
// data first and reload from the entry on an accepted read.
module tlbsr_regs
    import tlbsr_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned SEL_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  tlbsr_dec_t        dec,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DATA_W-1:0] entry_lo,
    input  logic [DATA_W-1:0] entry_hi,
    output logic [SEL_W-1:0]  sel_q,
    output logic [DATA_W-1:0] cause_q,
    output logic [DATA_W-1:0] mir_lo_q,
    output logic [DATA_W-1:0] mir_hi_q
);

    // Select register: only the way and index bits are kept.
    always_ff @(posedge clk) begin
        if (!rst_n)          sel_q <= '0;
        else if (dec.wr_sel) sel_q <= wr_data[SEL_W-1:0];
    end

    // Cause register: loaded only as a side effect of an entry-high write.
    always_ff @(posedge clk) begin
        if (!rst_n)         cause_q <= '0;
        else if (dec.wr_hi) cause_q <= wr_data;
    end

    // High mirror: written data, or a reload from the selected entry.
    always_ff @(posedge clk) begin
        if (!rst_n)          mir_hi_q <= '0;
        else if (dec.wr_hi)  mir_hi_q <= wr_data;
        else if (dec.reload) mir_hi_q <= entry_hi;
    end

    // Low mirror: written data, or a reload from the selected entry.
    always_ff @(posedge clk) begin
        if (!rst_n)          mir_lo_q <= '0;
        else if (dec.wr_lo)  mir_lo_q <= wr_data;
        else if (dec.reload) mir_lo_q <= entry_lo;
    end

endmodule

// File: rtl/tlbsr_inval.sv
// Page invalidate generator. Assumes it sees the old entry's page number
// and valid bit in the commit cycle. Issues a one-cycle request the cycle
// after, carrying the page-aligned address.
module tlbsr_inval #(
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned PAGE_SHIFT = 13
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         commit,
    input  logic [DATA_W-PAGE_SHIFT-1:0] old_page,
    input  logic                         old_valid,
    output logic                         inv_valid,
    output logic [DATA_W-1:0]            inv_addr,
    output logic                         inv_old_valid
);

    // Pulse on every commit; the address and flag hold between pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inv_valid     <= 1'b0;
            inv_addr      <= '0;
            inv_old_valid <= 1'b0;
        end else begin
            inv_valid <= commit;
            if (commit) begin
                inv_addr      <= {old_page, {PAGE_SHIFT{1'b0}}};
                inv_old_valid <= old_valid;
            end
        end
    end

endmodule

// File: rtl/tlb_support_bank.sv
// Top of the TLB support register bank. Software sets way and index
// through the select register, stages the high word through the cause
// register, and commits with a low-word write. Each commit asks for the
// old page to be invalidated. Reads return data one cycle after the strobe.
module tlb_support_bank
    import tlbsr_pkg::*;
#(
    parameter int unsigned       DATA_W     = 32,
    parameter int unsigned       SET_W      = 2,
    parameter int unsigned       IDX_W      = 4,
    parameter int unsigned       ADDR_W     = 4,
    parameter int unsigned       PAGE_SHIFT = 13,
    parameter int unsigned       VALID_BIT  = 3,
    parameter logic [ADDR_W-1:0] SEL_ADDR   = 4,
    parameter logic [ADDR_W-1:0] LO_ADDR    = 5,
    parameter logic [ADDR_W-1:0] HI_ADDR    = 6,
    parameter logic [ADDR_W-1:0] CAUSE_ADDR = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        bank_sel,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              inv_valid,
    output logic [DATA_W-1:0] inv_addr,
    output logic              inv_old_valid
);

    localparam int unsigned SEL_W = SET_W + IDX_W;

    tlbsr_dec_t        dec;
    logic [SEL_W-1:0]  sel_w;
    logic [DATA_W-1:0] cause_w;
    logic [DATA_W-1:0] mir_lo_w;
    logic [DATA_W-1:0] mir_hi_w;
    logic [DATA_W-1:0] cur_lo_w;
    logic [DATA_W-1:0] cur_hi_w;
    logic              rd_valid_q;
    logic              rd_active_q;
    logic [ADDR_W-1:0] rd_addr_q;

    tlbsr_decode #(
        .ADDR_W(ADDR_W), .SEL_ADDR(SEL_ADDR), .LO_ADDR(LO_ADDR), .HI_ADDR(HI_ADDR)
    ) u_decode (
        .bank_sel(bank_sel), .wr_en(wr_en), .rd_en(rd_en),
        .reg_addr(reg_addr), .dec(dec)
    );

    tlbsr_store #(.DATA_W(DATA_W), .SLOT_W(SEL_W)) u_store (
        .clk(clk), .rst_n(rst_n), .commit(dec.wr_lo), .bank(dec.bank),
        .slot(sel_w), .new_lo(wr_data), .new_hi(cause_w),
        .cur_lo(cur_lo_w), .cur_hi(cur_hi_w)
    );

    tlbsr_regs #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .dec(dec), .wr_data(wr_data),
        .entry_lo(cur_lo_w), .entry_hi(cur_hi_w),
        .sel_q(sel_w), .cause_q(cause_w), .mir_lo_q(mir_lo_w), .mir_hi_q(mir_hi_w)
    );

    tlbsr_inval #(.DATA_W(DATA_W), .PAGE_SHIFT(PAGE_SHIFT)) u_inval (
        .clk(clk), .rst_n(rst_n), .commit(dec.wr_lo),
        .old_page(cur_hi_w[DATA_W-1:PAGE_SHIFT]), .old_valid(cur_lo_w[VALID_BIT]),
        .inv_valid(inv_valid), .inv_addr(inv_addr), .inv_old_valid(inv_old_valid)
    );

    // Remember an accepted read so it can be answered next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid_q  <= 1'b0;
            rd_active_q <= 1'b0;
            rd_addr_q   <= '0;
        end else begin
            rd_valid_q <= dec.rd;
            if (dec.rd) begin
                rd_active_q <= dec.active;
                rd_addr_q   <= reg_addr;
            end
        end
    end

    // Return the requested register; mirrors already hold the reloaded entry.
    always_comb begin
        rd_data = '0;
        if (rd_valid_q && rd_active_q) begin
            case (rd_addr_q)
                SEL_ADDR:   rd_data = {{(DATA_W-SEL_W){1'b0}}, sel_w};
                LO_ADDR:    rd_data = mir_lo_w;
                HI_ADDR:    rd_data = mir_hi_w;
                CAUSE_ADDR: rd_data = cause_w;
                default:    rd_data = '0;
            endcase
        end
    end

    assign rd_valid = rd_valid_q;

endmodule

// File: rtl/tlbsr_checker.sv
// Property checker for the TLB support register bank, bound to the top.
// Watches the ports and the select and cause registers.
module tlbsr_checker #(
    parameter int unsigned       DATA_W     = 32,
    parameter int unsigned       ADDR_W     = 4,
    parameter int unsigned       SEL_W      = 6,
    parameter logic [ADDR_W-1:0] SEL_ADDR   = 4,
    parameter logic [ADDR_W-1:0] LO_ADDR    = 5,
    parameter logic [ADDR_W-1:0] HI_ADDR    = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        bank_sel,
    input logic              wr_en,
    input logic              rd_en,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              rd_valid,
    input logic [DATA_W-1:0] rd_data,
    input logic              inv_valid,
    input logic [SEL_W-1:0]  sel,
    input logic [DATA_W-1:0] cause
);

    logic act, commit, hi_wr, sel_wr;

    // Reference view of which accesses take effect.
    always_comb begin
        act    = (bank_sel == 2'd1) || (bank_sel == 2'd2);
        commit = wr_en && act && (reg_addr == LO_ADDR);
        hi_wr  = wr_en && act && (reg_addr == HI_ADDR);
        sel_wr = wr_en && act && (reg_addr == SEL_ADDR);
    end

    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!rd_valid && !inv_valid && sel == '0 && cause == '0));

    a_r2_inactive_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && !act) |=> (rd_valid && rd_data == '0));

    a_r3_sel_loads: assert property (@(posedge clk) disable iff (!rst_n)
        sel_wr |=> (sel == $past(wr_data[SEL_W-1:0])));

    a_r3_sel_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_wr |=> $stable(sel));

    a_r4_cause_loads: assert property (@(posedge clk) disable iff (!rst_n)
        hi_wr |=> (cause == $past(wr_data)));

    a_r5_cause_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !hi_wr |=> $stable(cause));

    a_r7_pulse_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> inv_valid);

    a_r7_no_stray_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> !inv_valid);

    a_r8_read_answered: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en) |=> rd_valid);

    a_r9_read_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && wr_en) |=> !rd_valid);

endmodule

bind tlb_support_bank tlbsr_checker #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SEL_W(SET_W + IDX_W),
    .SEL_ADDR(SEL_ADDR), .LO_ADDR(LO_ADDR), .HI_ADDR(HI_ADDR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bank_sel(bank_sel), .wr_en(wr_en), .rd_en(rd_en),
    .reg_addr(reg_addr), .wr_data(wr_data), .rd_valid(rd_valid), .rd_data(rd_data),
    .inv_valid(inv_valid), .sel(sel_w), .cause(cause_w)
);

// File: tb/sim_tlb_support_bank.sv
// Scoreboard bench: the driver task models each access and queues the
// expected read data and invalidate items; a monitor pops and compares them.
module sim_tlb_support_bank;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bank_sel = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] wr_data = '0;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic        inv_valid;
    logic [31:0] inv_addr;
    logic        inv_old_valid;

    tlb_support_bank u0 (
        .clk(clk), .rst_n(rst_n), .bank_sel(bank_sel), .wr_en(wr_en), .rd_en(rd_en),
        .reg_addr(reg_addr), .wr_data(wr_data), .rd_valid(rd_valid), .rd_data(rd_data),
        .inv_valid(inv_valid), .inv_addr(inv_addr), .inv_old_valid(inv_old_valid)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    bit live   = 1'b0;

    logic [31:0] rd_exp_q  [$];
    string       rd_tag_q  [$];
    logic [31:0] inv_exp_q [$];
    bit          invv_exp_q[$];
    string       inv_tag_q [$];

    // Reference state written from the requirements.
    logic [31:0] m_lo [2][64];
    logic [31:0] m_hi [2][64];
    logic [31:0] m_cause = '0;
    logic [5:0]  m_sel   = '0;

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One access: drive for one cycle, update the model, queue the expectations.
    task automatic op(input bit w, input bit r, input logic [1:0] b,
                      input logic [3:0] a, input logic [31:0] d, input string tag);
        bit act_b;
        int bk;
        @(negedge clk);
        wr_en = w; rd_en = r; bank_sel = b; reg_addr = a; wr_data = d;
        act_b = (b == 2'd1) || (b == 2'd2);
        bk = (b == 2'd2) ? 1 : 0;
        if (w) begin
            if (act_b) begin
                case (a)
                    4'd4: m_sel = d[5:0];
                    4'd6: m_cause = d;
                    4'd5: begin
                        inv_exp_q.push_back(m_hi[bk][m_sel] & 32'hFFFF_E000);
                        invv_exp_q.push_back(m_lo[bk][m_sel][3]);
                        inv_tag_q.push_back(tag);
                        m_lo[bk][m_sel] = d;
                        m_hi[bk][m_sel] = m_cause;
                    end
                    default: ;
                endcase
            end
        end else if (r) begin
            logic [31:0] e;
            e = '0;
            if (act_b) begin
                case (a)
                    4'd4: e = {26'd0, m_sel};
                    4'd5: e = m_lo[bk][m_sel];
                    4'd6: e = m_hi[bk][m_sel];
                    4'd7: e = m_cause;
                    default: e = '0;
                endcase
            end
            rd_exp_q.push_back(e);
            rd_tag_q.push_back(tag);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            wr_en = 1'b0; rd_en = 1'b0;
        end
    endtask

    // Monitor: compare every read answer and every invalidate with the queues.
    always @(negedge clk) begin
        if (live && rst_n) begin
            if (rd_valid) begin
                if (rd_exp_q.size() == 0) begin
                    check(1'b0, "R9 unexpected rd_valid", rd_data, 32'h0);
                end else begin
                    logic [31:0] e;
                    string t;
                    e = rd_exp_q.pop_front();
                    t = rd_tag_q.pop_front();
                    check(rd_data == e, t, rd_data, e);
                end
            end
            if (inv_valid) begin
                if (inv_exp_q.size() == 0) begin
                    check(1'b0, "R7/R2 unexpected inv_valid", inv_addr, 32'h0);
                end else begin
                    logic [31:0] e;
                    bit ev;
                    string t;
                    e  = inv_exp_q.pop_front();
                    ev = invv_exp_q.pop_front();
                    t  = inv_tag_q.pop_front();
                    check(inv_addr == e, {t, " inv_addr"}, inv_addr, e);
                    check(inv_old_valid == ev, {t, " inv_old_valid"},
                          {31'd0, inv_old_valid}, {31'd0, ev});
                end
            end
        end
    end

    task automatic finish_run();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        for (int b = 0; b < 2; b++)
            for (int i = 0; i < 64; i++) begin
                m_lo[b][i] = '0;
                m_hi[b][i] = '0;
            end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: outputs quiet after reset
        check(rd_valid == 1'b0, "R1 rd_valid after reset", {31'd0, rd_valid}, 32'd0);
        check(inv_valid == 1'b0, "R1 inv_valid after reset", {31'd0, inv_valid}, 32'd0);
        live = 1'b1;
        // R1: every register reads zero
        op(0, 1, 2'd1, 4'd4, 0, "R1 select zero");
        op(0, 1, 2'd1, 4'd5, 0, "R1 entry low zero");
        op(0, 1, 2'd1, 4'd6, 0, "R1 entry high zero");
        op(0, 1, 2'd1, 4'd7, 0, "R1 cause zero");
        // R3: select keeps bits [5:0]
        op(1, 0, 2'd1, 4'd4, 32'hABCD_EF3A, "R3");
        op(0, 1, 2'd1, 4'd4, 0, "R3 select readback");
        // R4/R5: cause loaded by high write, not by direct write
        op(1, 0, 2'd1, 4'd6, 32'h1234_6000, "R4");
        op(0, 1, 2'd1, 4'd7, 0, "R4 cause readback");
        op(1, 0, 2'd1, 4'd7, 32'h0000_DEAD, "R5");
        op(0, 1, 2'd1, 4'd7, 0, "R5 cause unchanged");
        // R6/R7: first commit replaces an empty entry
        op(1, 0, 2'd1, 4'd5, 32'h0000_000F, "R7 first commit");
        op(0, 1, 2'd1, 4'd5, 0, "R6 low word");
        op(0, 1, 2'd1, 4'd6, 0, "R6 high word from cause");
        // R7: second commit reports the old page and valid bit
        op(1, 0, 2'd1, 4'd6, 32'h5555_5FFF, "R4");
        op(1, 0, 2'd1, 4'd5, 32'h0000_0001, "R7 replace valid entry");
        // R8: uncommitted high write is hidden by the reload
        op(1, 0, 2'd1, 4'd6, 32'h7777_7777, "R4");
        op(0, 1, 2'd1, 4'd6, 0, "R8 reload shows stored high");
        op(0, 1, 2'd1, 4'd7, 0, "R8 cause keeps uncommitted value");
        // R10: the other bank is separate
        op(0, 1, 2'd2, 4'd5, 0, "R10 bank1 untouched");
        op(1, 0, 2'd2, 4'd5, 32'hCAFE_0008, "R10 commit bank1");
        op(0, 1, 2'd2, 4'd6, 0, "R10 bank1 high");
        op(0, 1, 2'd1, 4'd5, 0, "R10 bank0 low kept");
        // R2: inactive selector codes
        op(1, 0, 2'd0, 4'd4, 32'h0000_0011, "R2");
        op(1, 0, 2'd3, 4'd6, 32'h0BAD_0BAD, "R2");
        op(1, 0, 2'd3, 4'd5, 32'h0BAD_0BAD, "R2 no commit");
        op(0, 1, 2'd0, 4'd7, 0, "R2 inactive read zero");
        op(0, 1, 2'd3, 4'd4, 0, "R2 inactive read zero");
        op(0, 1, 2'd1, 4'd4, 0, "R2 select unchanged");
        op(0, 1, 2'd1, 4'd7, 0, "R2 cause unchanged");
        op(0, 1, 2'd2, 4'd5, 0, "R2 bank1 entry unchanged");
        // R11: unused address
        op(1, 0, 2'd1, 4'd2, 32'hFFFF_FFFF, "R11");
        op(0, 1, 2'd1, 4'd2, 0, "R11 unused reads zero");
        op(0, 1, 2'd1, 4'd15, 0, "R11 unused reads zero");
        // R9: write wins over read
        op(1, 1, 2'd1, 4'd4, 32'h0000_0005, "R9");
        op(0, 1, 2'd1, 4'd4, 0, "R9 write performed");
        // R6/R7/R10: sweep the ways of one index in both banks, twice
        for (int pass = 0; pass < 2; pass++)
            for (int bk = 1; bk <= 2; bk++)
                for (int s = 0; s < 4; s++) begin
                    op(1, 0, 2'(bk), 4'd4, 32'(s * 16 + 7), "R3");
                    op(1, 0, 2'(bk), 4'd6, 32'(s * 32'h1000_0000 + pass * 32'h2000 + bk * 32'h40_0000), "R4");
                    op(1, 0, 2'(bk), 4'd5, 32'(s + 8 * pass + 2 * bk), "R7 sweep commit");
                end
        for (int bk = 1; bk <= 2; bk++)
            for (int s = 0; s < 4; s++) begin
                op(1, 0, 2'(bk), 4'd4, 32'(s * 16 + 7), "R3");
                op(0, 1, 2'(bk), 4'd5, 0, "R10 sweep low");
                op(0, 1, 2'(bk), 4'd6, 0, "R10 sweep high");
            end
        // R7: back-to-back commits give back-to-back pulses
        op(1, 0, 2'd1, 4'd6, 32'hA000_2000, "R4");
        op(1, 0, 2'd1, 4'd5, 32'h0000_0009, "R7 back-to-back 1");
        op(1, 0, 2'd1, 4'd5, 32'h0000_0000, "R7 back-to-back 2");
        idle(4);
        check(rd_exp_q.size() == 0, "R8 reads unanswered", 32'(rd_exp_q.size()), 32'd0);
        check(inv_exp_q.size() == 0, "R7 invalidates missing", 32'(inv_exp_q.size()), 32'd0);
        finish_run();
    end

endmodule